// File: doc/BRIEF.md
# SMBus Descriptor Transaction Executor

This block accepts one transaction descriptor (an address byte carrying the R/W bit, a byte that is either a command or a write length, a read length and a control byte) and carries out the SMBus or raw I2C transaction it describes. The flag bits in the control byte pick the form: quick command, send/receive byte, byte and word writes and reads, process call, SMBus block write and read, and raw I2C block transfers. Optional packet error checking can be added to any of these forms.

It does no bit-level timing of its own. Each bus step (start, write one byte, read one byte with ACK or NACK, stop) is handed to a byte-level bus engine through a request/done handshake. The engine reports whether the target acknowledged, any byte that was read, and whether a collision or a timeout occurred. Write data comes from a small external data buffer through a read port, and read data goes back to it through a write port. At the end the block reports a one-hot status byte together with the counts of transmitted and received bytes.

Top module: `smbus_desc_exec`

## Requirements
- R1: The engine op code is 0 for start, 1 for write byte, 2 for read byte and 3 for stop, and only one op is requested at a time. The first byte after start is the descriptor address byte. Its bit 0 is forced to 0 when write bytes follow, and is passed through unchanged otherwise. The address byte sent after a repeated start always has bit 0 set to 1.
- R2: When control bit 0 is set, the second descriptor byte is sent as the only write byte. When control bit 0 is clear, that byte gives the number of bytes to write, taken from buffer indices 0, 1, 2 and onward.
- R3: A quick command (zero write bytes, read length 0) sends start, the address byte and stop. It ends with status 0x01 and both counts equal to 0.
- R4: In an SMBus block write (control bit 2 set, bits 0 and 5 clear, read length 0), a count byte equal to the write length minus one is inserted right after buffer byte 0.
- R5: In an SMBus block read (control bit 2 set, bit 5 clear, read length nonzero), the first byte read is a count n, stored at buffer index 0. Then n more bytes are read, and the received count is n+1. If n is greater than MAX_BLOCK (32), the block stops after the count byte with status 0x80 and a received count of 1.
- R6: When write bytes are followed by a nonzero read length, the block issues a repeated start, sends the read address byte and then reads. Read bytes are stored at buffer index 0 and upward, which covers the process call and the raw I2C block read.
- R7: Every read byte is acknowledged except the last one, which gets a NACK. With PEC enabled, the last read byte is the PEC byte.
- R8: PEC applies when control bit 4 is set, control bit 5 is clear and at least one byte beyond the address is moved. The PEC is CRC-8 with polynomial x^8+x^2+x+1 and initial value 0, computed over every address, command, count and data byte. On writes it is appended as an extra byte. On reads it is read as an extra byte and compared, and a mismatch gives status 0x10.
- R9: If the target NAKs any written byte, the block issues stop and reports status 0x08. The transmitted count includes only the acknowledged bytes.
- R10: A collision reported by the engine ends the transaction at once with status 0x40, a clock-low timeout with 0x20 and a data-low timeout with 0x04. No stop is issued in these cases.
- R11: At the end the block pulses wb_valid for one cycle together with the status, the tx count and the rx count. On success the status is 0x01. Neither count includes address bytes or PEC bytes.
- R12: busy rises in the cycle after go is accepted and falls one cycle after the wb_valid pulse. A go asserted while busy is high is ignored.
- R13: When control bit 6 is set, irq pulses together with wb_valid. When control bit 3 is set, fair goes high once the first start completes without a collision. fair is cleared when the next go is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start request; sampled only while idle |
| d_addr | input | 8 | Target address in bits 7:1, R/W in bit 0 |
| d_lencmd | input | 8 | Command byte, or number of bytes to write |
| d_rdlen | input | 8 | Number of bytes to read |
| d_ctrl | input | 8 | Control flags |
| busy | output | 1 | Transaction in progress |
| eng_req | output | 1 | One-cycle request to the bus engine |
| eng_op | output | 2 | Engine op: 0 start, 1 write, 2 read, 3 stop |
| eng_wdata | output | 8 | Byte to write |
| eng_nack | output | 1 | Send NACK after this read |
| eng_done | input | 1 | Engine finished the requested op |
| eng_ack | input | 1 | Target acknowledged the written byte |
| eng_rdata | input | 8 | Byte read by the engine |
| eng_col | input | 1 | Collision during the op |
| eng_dlto | input | 1 | Data-low timeout during the op |
| eng_clto | input | 1 | Clock-low timeout during the op |
| buf_raddr | output | AW | Buffer read index |
| buf_rdata | input | 8 | Buffer byte at buf_raddr |
| buf_we | output | 1 | Buffer write strobe |
| buf_waddr | output | AW | Buffer write index |
| buf_wdata | output | 8 | Byte to store |
| wb_valid | output | 1 | Write-back pulse |
| wb_status | output | 8 | One-hot status code |
| wb_rxcnt | output | 8 | Bytes stored into the buffer |
| wb_txcnt | output | 8 | Non-address, non-PEC bytes acknowledged |
| irq | output | 1 | Completion interrupt pulse |
| fair | output | 1 | Start completed without a collision while fairness was requested |

## Verification
The bench uses the default parameters, BUF_DEPTH = 64 and MAX_BLOCK = 32. This buffer depth holds a full block read together with its count byte. The block limit lets the bench reach the oversized case with a count of 33 using a single short read. The bench acts as the bus target and can inject a NAK, a collision or either timeout at any chosen op index, which reaches every status code.

// File: rtl/smbus_desc_exec.sv
module smbus_desc_exec #(
  parameter int BUF_DEPTH = 64,
  parameter int MAX_BLOCK = 32,
  localparam int AW = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [7:0]    d_addr,
  input  logic [7:0]    d_lencmd,
  input  logic [7:0]    d_rdlen,
  input  logic [7:0]    d_ctrl,
  output logic          busy,
  output logic          eng_req,
  output logic [1:0]    eng_op,
  output logic [7:0]    eng_wdata,
  output logic          eng_nack,
  input  logic          eng_done,
  input  logic          eng_ack,
  input  logic [7:0]    eng_rdata,
  input  logic          eng_col,
  input  logic          eng_dlto,
  input  logic          eng_clto,
  output logic [AW-1:0] buf_raddr,
  input  logic [7:0]    buf_rdata,
  output logic          buf_we,
  output logic [AW-1:0] buf_waddr,
  output logic [7:0]    buf_wdata,
  output logic          wb_valid,
  output logic [7:0]    wb_status,
  output logic [7:0]    wb_rxcnt,
  output logic [7:0]    wb_txcnt,
  output logic          irq,
  output logic          fair
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_WRITE, S_WCNT, S_RSTART, S_RADDR,
    S_READ, S_PECW, S_PECR, S_STOP, S_WB, S_FIN
  } state_t;

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  state_t st;
  logic       pend;
  logic [7:0] a_r, lc_r, rl_r, ctl_r;
  logic [7:0] wi, ri, tx, rx, crc, code;
  logic [8:0] rd_tgt;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  wire       cmd_f = ctl_r[0];
  wire       blk_f = ctl_r[2];
  wire       pec_f = ctl_r[4];
  wire       i2c_f = ctl_r[5];
  wire [7:0] wr_total = cmd_f ? 8'd1 : lc_r;
  wire       has_wr = wr_total != 8'd0;
  wire       has_rd = rl_r != 8'd0;
  wire       pec_on = pec_f & ~i2c_f & (has_wr | has_rd);
  wire       blkw = blk_f & ~i2c_f & ~cmd_f & ~has_rd;
  wire       blkr = blk_f & ~i2c_f & has_rd;
  wire       err_any = eng_col | eng_clto | eng_dlto;
  wire [7:0] err_code = eng_col ? 8'h40 : (eng_clto ? 8'h20 : 8'h04);
  wire       last_rd = ({1'b0, ri} + 9'd1) == rd_tgt;

  state_t after_wr, after_rd;
  assign after_wr = has_rd ? S_RSTART : (pec_on ? S_PECW : S_STOP);
  assign after_rd = pec_on ? S_PECR : S_STOP;

  assign buf_raddr = wi[AW-1:0];

  logic [1:0] op_c;
  logic [7:0] byte_c;
  logic       nack_c;

  always_comb begin
    op_c   = OP_WRITE;
    byte_c = 8'h00;
    nack_c = 1'b0;
    case (st)
      S_START, S_RSTART: op_c = OP_START;
      S_ADDR:   byte_c = {a_r[7:1], has_wr ? 1'b0 : a_r[0]};
      S_WRITE:  byte_c = cmd_f ? lc_r : buf_rdata;
      S_WCNT:   byte_c = lc_r - 8'd1;
      S_RADDR:  byte_c = {a_r[7:1], 1'b1};
      S_PECW:   byte_c = crc;
      S_READ: begin
        op_c   = OP_READ;
        nack_c = ~pec_on & ~(blkr & (ri == 8'd0)) & last_rd;
      end
      S_PECR: begin
        op_c   = OP_READ;
        nack_c = 1'b1;
      end
      S_STOP:   op_c = OP_STOP;
      default:  op_c = OP_WRITE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  pend <= 1'b0;  busy <= 1'b0;
      a_r <= '0;  lc_r <= '0;  rl_r <= '0;  ctl_r <= '0;
      wi <= '0;  ri <= '0;  tx <= '0;  rx <= '0;  crc <= '0;  code <= '0;
      rd_tgt <= '0;
      eng_req <= 1'b0;  eng_op <= OP_START;  eng_wdata <= '0;  eng_nack <= 1'b0;
      buf_we <= 1'b0;  buf_waddr <= '0;  buf_wdata <= '0;
      wb_valid <= 1'b0;  wb_status <= '0;  wb_rxcnt <= '0;  wb_txcnt <= '0;
      irq <= 1'b0;  fair <= 1'b0;
    end else begin
      eng_req  <= 1'b0;
      buf_we   <= 1'b0;
      wb_valid <= 1'b0;
      irq      <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          a_r <= d_addr;  lc_r <= d_lencmd;  rl_r <= d_rdlen;  ctl_r <= d_ctrl;
          busy <= 1'b1;  fair <= 1'b0;  code <= 8'h01;  crc <= 8'h00;
          wi <= '0;  ri <= '0;  tx <= '0;  rx <= '0;
          rd_tgt <= {1'b0, d_rdlen};
          pend <= 1'b0;
          st <= S_START;
        end
        S_WB: begin
          wb_valid  <= 1'b1;
          wb_status <= code;
          wb_rxcnt  <= rx;
          wb_txcnt  <= tx;
          irq       <= ctl_r[6];
          st        <= S_FIN;
        end
        S_FIN: begin
          busy <= 1'b0;
          st   <= S_IDLE;
        end
        default: begin
          if (!pend) begin
            eng_req   <= 1'b1;
            eng_op    <= op_c;
            eng_wdata <= byte_c;
            eng_nack  <= nack_c;
            pend      <= 1'b1;
          end else if (eng_done) begin
            pend <= 1'b0;
            if (st == S_STOP) begin
              st <= S_WB;
            end else if (err_any) begin
              code <= err_code;
              st   <= S_WB;
            end else if (op_c == OP_WRITE && !eng_ack) begin
              code <= 8'h08;
              st   <= S_STOP;
            end else begin
              if (st == S_ADDR || st == S_WRITE || st == S_WCNT || st == S_RADDR)
                crc <= crc8(crc, eng_wdata);
              if (st == S_READ)
                crc <= crc8(crc, eng_rdata);
              case (st)
                S_START: begin
                  if (ctl_r[3]) fair <= 1'b1;
                  st <= S_ADDR;
                end
                S_RSTART: st <= S_RADDR;
                S_ADDR: st <= has_wr ? S_WRITE : (has_rd ? S_READ : S_STOP);
                S_WRITE: begin
                  tx <= tx + 8'd1;
                  wi <= wi + 8'd1;
                  if (blkw && wi == 8'd0) st <= S_WCNT;
                  else if (wi + 8'd1 == wr_total) st <= after_wr;
                  else st <= S_WRITE;
                end
                S_WCNT: begin
                  tx <= tx + 8'd1;
                  st <= (wi == wr_total) ? after_wr : S_WRITE;
                end
                S_RADDR: st <= S_READ;
                S_READ: begin
                  buf_we    <= 1'b1;
                  buf_waddr <= ri[AW-1:0];
                  buf_wdata <= eng_rdata;
                  rx <= rx + 8'd1;
                  ri <= ri + 8'd1;
                  if (blkr && ri == 8'd0) begin
                    if (eng_rdata > 8'(MAX_BLOCK)) begin
                      code <= 8'h80;
                      st   <= S_STOP;
                    end else if (eng_rdata == 8'd0) begin
                      st <= after_rd;
                    end else begin
                      rd_tgt <= {1'b0, eng_rdata} + 9'd1;
                      st     <= S_READ;
                    end
                  end else begin
                    st <= last_rd ? after_rd : S_READ;
                  end
                end
                S_PECW: st <= S_STOP;
                S_PECR: begin
                  if (eng_rdata != crc) code <= 8'h10;
                  st <= S_STOP;
                end
                default: st <= S_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/smbus_desc_exec_chk.sv
module smbus_desc_exec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       eng_req,
  input logic [1:0] eng_op,
  input logic       eng_nack,
  input logic       wb_valid,
  input logic [7:0] wb_status,
  input logic       irq
);

  a_r12_busy_falls_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !busy);

  a_r12_wb_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy);

  a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wb_valid) |=> busy);

  a_r1_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);

  a_r7_nack_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_nack) |-> eng_op == 2'd2);

  a_r11_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $countones(wb_status) == 1);

  a_r13_irq_with_wb: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wb_valid);

endmodule

bind smbus_desc_exec smbus_desc_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .eng_req(eng_req), .eng_op(eng_op),
  .eng_nack(eng_nack), .wb_valid(wb_valid), .wb_status(wb_status), .irq(irq)
);

// File: tb/smbus_desc_exec_test.sv
`timescale 1ns/1ps
module smbus_desc_exec_test;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, go, busy, eng_req, eng_nack, eng_done, eng_ack, eng_col, eng_dlto, eng_clto;
  logic [7:0] d_addr, d_lencmd, d_rdlen, d_ctrl, eng_wdata, eng_rdata, buf_rdata, buf_wdata;
  logic [7:0] wb_status, wb_rxcnt, wb_txcnt;
  logic [1:0] eng_op;
  logic [AW-1:0] buf_raddr, buf_waddr;
  logic buf_we, wb_valid, irq, fair;

  smbus_desc_exec uut (.*);

  logic [7:0] mem [64];
  logic ld_we = 1'b0;
  logic [AW-1:0] ld_a = '0;
  logic [7:0] ld_d = '0;
  assign buf_rdata = mem[buf_raddr];
  always @(posedge clk) begin
    if (buf_we) mem[buf_waddr] <= buf_wdata;
    else if (ld_we) mem[ld_a] <= ld_d;
  end

  typedef struct { logic [1:0] op; logic nk; logic [7:0] b; string tag; } op_t;
  typedef struct { logic [7:0] st; logic [7:0] tx; logic [7:0] rx; logic irq; string tag; } wb_t;
  op_t exp_q[$];
  wb_t wb_q[$];
  logic [7:0] rd_q[$];
  op_t e;
  wb_t w;

  int n_chk = 0, n_fail = 0, cyc = 0, wb_cyc = 0;
  int opn = 0, nak_op = -1, err_op = -1, err_kind = 0;
  logic [7:0] bc;
  string cur_tag = "R12";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic nk, input logic [7:0] b, input string tag);
    op_t t;
    t.op = op; t.nk = nk; t.b = b; t.tag = tag;
    exp_q.push_back(t);
  endtask
  task automatic s_(input string tag); push(2'd0, 1'b0, 8'h00, tag); endtask
  task automatic p_(input string tag); push(2'd3, 1'b0, 8'h00, tag); endtask
  task automatic wr(input logic [7:0] b, input string tag);
    push(2'd1, 1'b0, b, tag); bc = crc8(bc, b);
  endtask
  task automatic rd(input logic [7:0] b, input logic nk, input string tag);
    push(2'd2, nk, 8'h00, tag); rd_q.push_back(b); bc = crc8(bc, b);
  endtask
  task automatic exp_wb(input logic [7:0] st, input logic [7:0] tx, input logic [7:0] rx,
                        input logic ir, input string tag);
    wb_t t;
    t.st = st; t.tx = tx; t.rx = rx; t.irq = ir; t.tag = tag;
    wb_q.push_back(t);
  endtask
  task automatic load(input int a, input logic [7:0] d);
    @(negedge clk); ld_we = 1'b1; ld_a = AW'(a); ld_d = d;
    @(negedge clk); ld_we = 1'b0;
  endtask

  // bus target model and op scoreboard
  initial begin
    eng_done = 0; eng_ack = 0; eng_rdata = 0; eng_col = 0; eng_dlto = 0; eng_clto = 0;
    forever begin
      @(negedge clk);
      if (eng_req) begin
        if (exp_q.size() == 0) check(0, cur_tag, "unexpected engine op", eng_op, 0);
        else begin
          e = exp_q.pop_front();
          check(eng_op == e.op, e.tag, "engine op", eng_op, e.op);
          if (e.op == 2'd1) check(eng_wdata == e.b, e.tag, "written byte", eng_wdata, e.b);
          if (e.op == 2'd2) check(eng_nack == e.nk, e.tag, "read nack", eng_nack, e.nk);
        end
        @(negedge clk);
        eng_done = 1;
        eng_ack = (opn != nak_op);
        eng_rdata = (eng_op == 2'd2 && rd_q.size() > 0) ? rd_q.pop_front() : 8'h00;
        eng_col = (opn == err_op && err_kind == 0);
        eng_clto = (opn == err_op && err_kind == 1);
        eng_dlto = (opn == err_op && err_kind == 2);
        opn++;
        @(negedge clk);
        eng_done = 0; eng_col = 0; eng_clto = 0; eng_dlto = 0;
      end
    end
  end

  // write-back monitor
  initial begin
    forever begin
      @(negedge clk);
      if (wb_valid) begin
        wb_cyc = cyc;
        if (wb_q.size() == 0) check(0, cur_tag, "unexpected write-back", wb_status, 0);
        else begin
          w = wb_q.pop_front();
          check(wb_status == w.st, w.tag, "status", wb_status, w.st);
          check(wb_txcnt == w.tx, w.tag, "tx count", wb_txcnt, w.tx);
          check(wb_rxcnt == w.rx, w.tag, "rx count", wb_rxcnt, w.rx);
          check(irq == w.irq, "R13", "irq", irq, w.irq);
        end
      end
    end
  end

  task automatic launch(input logic [7:0] a, input logic [7:0] lc, input logic [7:0] rl,
                        input logic [7:0] ct, input string tag, input bit poke);
    cur_tag = tag;
    opn = 0;
    @(negedge clk);
    d_addr = a; d_lencmd = lc; d_rdlen = rl; d_ctrl = ct; go = 1;
    @(negedge clk);
    go = 0;
    check(busy == 1'b1, "R12", "busy after go", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      d_addr = 8'h5C; d_lencmd = 8'h01; d_ctrl = 8'h01; go = 1;
      @(negedge clk);
      go = 0;
    end
    while (busy) @(negedge clk);
    check(cyc - wb_cyc == 1, "R12", "busy fall delay", cyc - wb_cyc, 1);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, tag, "ops missing", exp_q.size(), 0);
    check(wb_q.size() == 0, tag, "write-back missing", wb_q.size(), 0);
    rd_q.delete();
    nak_op = -1; err_op = -1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; go = 0; d_addr = 0; d_lencmd = 0; d_rdlen = 0; d_ctrl = 0;
    repeat (3) @(negedge clk);
    check(busy == 0, "R12", "reset busy", busy, 0);
    check(eng_req == 0, "R1", "reset eng_req", eng_req, 0);
    check(wb_valid == 0, "R11", "reset wb_valid", wb_valid, 0);
    check(fair == 0, "R13", "reset fair", fair, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R3 quick write
    bc = 0; s_("R3"); wr(8'hA0, "R1"); p_("R3");
    exp_wb(8'h01, 0, 0, 0, "R3");
    launch(8'hA0, 8'h00, 8'h00, 8'h00, "R3", 0);

    // R2 send byte with command flag, R13 irq
    bc = 0; s_("R2"); wr(8'hA0, "R1"); wr(8'h3C, "R2"); p_("R2");
    exp_wb(8'h01, 1, 0, 1, "R2");
    launch(8'hA0, 8'h3C, 8'h00, 8'h41, "R2", 0);

    // R2 + R8 buffered write with PEC
    load(0, 8'h10); load(1, 8'h11); load(2, 8'h12);
    bc = 0; s_("R8"); wr(8'hA0, "R1"); wr(8'h10, "R2"); wr(8'h11, "R2"); wr(8'h12, "R2");
    push(2'd1, 1'b0, bc, "R8"); p_("R8");
    exp_wb(8'h01, 3, 0, 0, "R8");
    launch(8'hA0, 8'h03, 8'h00, 8'h10, "R8", 0);

    // R4 block write with count insertion
    load(0, 8'h20); load(1, 8'h21); load(2, 8'h22);
    bc = 0; s_("R4"); wr(8'hA0, "R4"); wr(8'h20, "R4"); wr(8'h02, "R4");
    wr(8'h21, "R4"); wr(8'h22, "R4"); p_("R4");
    exp_wb(8'h01, 4, 0, 0, "R4");
    launch(8'hA0, 8'h03, 8'h00, 8'h04, "R4", 0);

    // R6 + R1 + R7 read byte with command
    bc = 0; s_("R6"); wr(8'hA0, "R1"); wr(8'h05, "R6"); s_("R6"); wr(8'hA1, "R1");
    rd(8'h77, 1, "R7"); p_("R6");
    exp_wb(8'h01, 1, 1, 0, "R6");
    launch(8'hA1, 8'h05, 8'h01, 8'h01, "R6", 0);
    check(mem[0] == 8'h77, "R6", "stored byte", mem[0], 8'h77);

    // R6 + R8 process call with good PEC
    load(0, 8'h30); load(1, 8'h31); load(2, 8'h32);
    bc = 0; s_("R6"); wr(8'hA0, "R1"); wr(8'h30, "R6"); wr(8'h31, "R6"); wr(8'h32, "R6");
    s_("R6"); wr(8'hA1, "R1"); rd(8'h5A, 0, "R7"); rd(8'hC3, 0, "R7");
    push(2'd2, 1'b1, 8'h00, "R8"); rd_q.push_back(bc); p_("R8");
    exp_wb(8'h01, 3, 2, 0, "R8");
    launch(8'hA0, 8'h03, 8'h02, 8'h10, "R8", 0);
    check(mem[0] == 8'h5A && mem[1] == 8'hC3, "R6", "process call data", {mem[1], mem[0]}, 16'hC35A);

    // R8 PEC mismatch
    load(0, 8'h30); load(1, 8'h31); load(2, 8'h32);
    bc = 0; s_("R8"); wr(8'hA0, "R8"); wr(8'h30, "R8"); wr(8'h31, "R8"); wr(8'h32, "R8");
    s_("R8"); wr(8'hA1, "R8"); rd(8'h5A, 0, "R8"); rd(8'hC3, 0, "R8");
    push(2'd2, 1'b1, 8'h00, "R8"); rd_q.push_back(bc ^ 8'hFF); p_("R8");
    exp_wb(8'h10, 3, 2, 0, "R8");
    launch(8'hA0, 8'h03, 8'h02, 8'h10, "R8", 0);

    // R5 block read, count 3
    bc = 0; s_("R5"); wr(8'hA0, "R5"); wr(8'h07, "R5"); s_("R5"); wr(8'hA1, "R5");
    rd(8'h03, 0, "R5"); rd(8'h41, 0, "R7"); rd(8'h42, 0, "R7"); rd(8'h43, 1, "R7"); p_("R5");
    exp_wb(8'h01, 1, 4, 0, "R5");
    launch(8'hA1, 8'h07, 8'd32, 8'h05, "R5", 0);
    check(mem[0] == 8'h03 && mem[3] == 8'h43, "R5", "block data", {mem[0], mem[3]}, 16'h0343);

    // R5 oversized count
    bc = 0; s_("R5"); wr(8'hA0, "R5"); wr(8'h07, "R5"); s_("R5"); wr(8'hA1, "R5");
    rd(8'd33, 0, "R5"); p_("R5");
    exp_wb(8'h80, 1, 1, 0, "R5");
    launch(8'hA1, 8'h07, 8'd32, 8'h05, "R5", 0);

    // R6 raw I2C block read, PEC flag has no effect in raw mode
    bc = 0; s_("R6"); wr(8'hA0, "R6"); wr(8'h09, "R6"); s_("R6"); wr(8'hA1, "R6");
    rd(8'h66, 0, "R7"); rd(8'h67, 1, "R7"); p_("R6");
    exp_wb(8'h01, 1, 2, 0, "R6");
    launch(8'hA0, 8'h09, 8'h02, 8'h31, "R6", 0);
    check(mem[1] == 8'h67, "R6", "i2c read byte", mem[1], 8'h67);

    // R9 NAK on second data byte
    load(0, 8'h50); load(1, 8'h51); load(2, 8'h52);
    nak_op = 3;
    bc = 0; s_("R9"); wr(8'hA0, "R9"); wr(8'h50, "R9"); wr(8'h51, "R9"); p_("R9");
    exp_wb(8'h08, 1, 0, 0, "R9");
    launch(8'hA0, 8'h03, 8'h00, 8'h00, "R9", 0);

    // R10 collision on start, fairness not granted
    err_op = 0; err_kind = 0;
    s_("R10");
    exp_wb(8'h40, 0, 0, 0, "R10");
    launch(8'hA0, 8'h00, 8'h00, 8'h08, "R10", 0);
    check(fair == 0, "R13", "fair after collision", fair, 0);

    // R13 fairness granted
    s_("R13"); wr(8'hA0, "R13"); p_("R13");
    exp_wb(8'h01, 0, 0, 0, "R13");
    launch(8'hA0, 8'h00, 8'h00, 8'h08, "R13", 0);
    check(fair == 1, "R13", "fair after won start", fair, 1);

    // R10 clock-low timeout on address, no stop
    err_op = 1; err_kind = 1;
    s_("R10"); wr(8'hA0, "R10");
    exp_wb(8'h20, 0, 0, 0, "R10");
    launch(8'hA0, 8'h00, 8'h00, 8'h00, "R10", 0);

    // R10 data-low timeout on receive byte; R1 address bit 0 kept
    err_op = 2; err_kind = 2;
    s_("R10"); wr(8'hA1, "R1"); rd(8'h11, 1, "R10");
    exp_wb(8'h04, 0, 0, 0, "R10");
    launch(8'hA1, 8'h00, 8'h01, 8'h00, "R10", 0);

    // R12 go while busy is ignored
    s_("R12"); wr(8'hA0, "R12"); p_("R12");
    exp_wb(8'h01, 0, 0, 0, "R12");
    launch(8'hA0, 8'h00, 8'h00, 8'h00, "R12", 1);
    repeat (20) @(negedge clk);
    check(busy == 0, "R12", "no restart from ignored go", busy, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule